// File: doc/BRIEF.md
# Upward-growing stack pointer with limit and floor traps

This block owns the stack pointer of a 16-bit data space and turns stack commands into data-memory accesses. The stack grows toward higher addresses, and the pointer always holds the address of the next free word. A single-word push writes at the pointer and then advances it by one word. A pop first steps the pointer back by one word and then reads at the new value. A subroutine call or an exception entry stores the 23-bit program counter as a two-word frame over two consecutive cycles. Reading the data that a pop returns, vectoring the trap, and decoding instructions are left to the surrounding core.

Every effective address the block issues is checked against two bounds. The first is a programmable upper limit. The limit register is not reset, and its check is armed only after the first write to it. A push at an address equal to the limit is allowed, and any access above the limit traps. The second bound is a fixed floor at 0x0800, which shields the special-register region below it. Any access below the floor traps. The trap is a pulse in the cycle of the offending access. That access still happens, the pointer still moves, and a sticky error flag records the event until software clears it. After a limit write, the block refuses commands for one settle cycle. This means no stack access can use a limit value that is still being written.

Control is a three-state machine. `ST_IDLE` accepts commands. `ST_FRAME_HI` writes the upper frame word. `ST_LIM_SETTLE` is the stall after a limit write. The transitions are:
- IDLE→FRAME_HI on an accepted call or exception.
- IDLE→LIM_SETTLE on a limit write.
- FRAME_HI→IDLE, or FRAME_HI→LIM_SETTLE if the limit is written during the upper-word cycle.
- LIM_SETTLE→IDLE, or LIM_SETTLE→LIM_SETTLE while limit writes continue.

Top module: `stkptr_unit`

## Requirements
- R1: While reset is held and just after it is released, `sp_out` is 0x0800, `cmd_ready` is 1, and `trap`, `err_flag`, `mem_we` and `mem_re` are 0.
- R2: An accepted push (`cmd_op` = 0) writes `push_data` at `mem_addr` = `sp_out` in the same cycle, with `mem_we` = 1. `sp_out` is 2 higher in the next cycle.
- R3: An accepted pop (`cmd_op` = 1) drives `mem_re` = 1 with `mem_addr` = `sp_out` − 2 in the same cycle. `sp_out` is 2 lower in the next cycle.
- R4: Bit 0 of `sp_out` is always 0. Bit 0 of `lim_wdata` is ignored: writing 0x0811 places the trap boundary exactly where 0x0810 would.
- R5: Once the limit has been written, an access whose address is greater than the limit pulses `trap`. An access at an address equal to or below the limit does not. Before the first limit write, the limit causes no trap.
- R6: Any access whose address is below 0x0800 pulses `trap`. This includes a pop straight after reset, which reads at 0x07FE.
- R7: An accepted call (`cmd_op` = 2) writes PC[15:0] at `sp_out`. In the next cycle, with `cmd_ready` = 0, it writes {9'b0, PC[22:16]} at the following word. The pointer advances by 4 in total.
- R8: An accepted exception (`cmd_op` = 3) writes the same first word as a call. Its second word is {status[7:0], 1'b0, PC[22:16]}.
- R9: `cmd_ready` is 0 in the cycle where `lim_we` is 1 and in the cycle that follows it.
- R10: `trap` is high only in a cycle with a memory access. A trapping access still performs its read or write and still moves the pointer. `err_flag` is 1 from the cycle after a trap until an `err_clr` that does not coincide with a trap.
- R11: A command presented while `cmd_ready` is 0 has no effect: no memory access is made and `sp_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 exception |
| cmd_ready | output | 1 | A command is accepted this cycle |
| push_data | input | 16 | Word to store on a push |
| pc_in | input | 23 | Program counter for call and exception frames |
| status_in | input | 8 | Low status byte for exception frames |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 16 | New limit (bit 0 ignored) |
| err_clr | input | 1 | Clears the sticky error flag |
| mem_addr | output | 16 | Effective byte address of the stack access |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| sp_out | output | 16 | Current stack pointer |
| trap | output | 1 | Stack-error pulse |
| err_flag | output | 1 | Sticky stack-error flag |

## Verification
Two pairs of functions can land in the same cycle. A limit write can meet an incoming push. A trapping push can meet a software clear of the error flag. The bench raises `lim_we` together with a push command. It then expects the push to be dropped in both stall cycles, leaving the pointer untouched. In a later test it issues a push past the limit with `err_clr` high, and it requires the flag to stay set. Alongside these, a reference model of pointer, limit and flag predicts every address, data word and trap pulse, both across a table of mixed operations and across floor and limit crossings.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_EXC  = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FRAME_HI   = 2'd1,
        ST_LIM_SETTLE = 2'd2
    } stk_state_e;

endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
    parameter int              AW      = 16,
    parameter logic [AW-1:0]   RST_VAL = 16'h0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_back
);
    // word index: bit 0 of the byte address is never stored
    localparam logic [AW-2:0] RST_IDX = RST_VAL[AW-1:1];
    localparam logic [AW-2:0] ONE_W   = (AW-1)'(1);

    logic [AW-2:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= RST_IDX;
        else if (inc)
            idx_q <= idx_q + ONE_W;
        else if (dec)
            idx_q <= idx_q - ONE_W;
    end

    assign sp      = {idx_q, 1'b0};
    assign sp_back = {idx_q - ONE_W, 1'b0};
endmodule

// File: rtl/stk_bound_chk.sv
module stk_bound_chk #(
    parameter int            AW    = 16,
    parameter logic [AW-1:0] FLOOR = 16'h0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lim_we,
    input  logic [AW-1:0] lim_wdata,
    input  logic          ea_valid,
    input  logic [AW-1:0] ea,
    output logic          hit
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

    logic [AW-1:0] lim_q;
    logic          armed_q;

    // limit register deliberately has no reset
    always_ff @(posedge clk) begin
        if (lim_we)
            lim_q <= lim_wdata & ALIGN_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (lim_we)
            armed_q <= 1'b1;
    end

    always_comb begin
        hit = 1'b0;
        if (ea_valid) begin
            if (ea < FLOOR)
                hit = 1'b1;
            else if (armed_q && (ea > lim_q))
                hit = 1'b1;
        end
    end
endmodule

// File: rtl/stk_frame_fmt.sv
module stk_frame_fmt #(
    parameter int AW  = 16,
    parameter int PCW = 23,
    parameter int STW = 8
) (
    input  logic [PCW-1:0] pc,
    input  logic [STW-1:0] status,
    input  logic           is_exc,
    output logic [AW-1:0]  lo_word,
    output logic [AW-1:0]  hi_word
);
    localparam int HIW = PCW - AW;

    logic [AW-1:0] hi_call;
    logic [AW-1:0] hi_exc;

    always_comb begin
        lo_word             = pc[AW-1:0];
        hi_call             = AW'(pc[PCW-1:AW]);
        hi_exc              = hi_call;
        hi_exc[AW-1 -: STW] = status;
        hi_word             = is_exc ? hi_exc : hi_call;
    end

    initial begin
        if (HIW + STW >= AW)
            $error("frame upper word cannot hold status and PC bits");
    end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit #(
    parameter int            AW       = 16,
    parameter int            PCW      = 23,
    parameter int            STW      = 8,
    parameter logic [AW-1:0] FLOOR    = 16'h0800,
    parameter logic [AW-1:0] SP_RESET = 16'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    output logic           cmd_ready,
    input  logic [AW-1:0]  push_data,
    input  logic [PCW-1:0] pc_in,
    input  logic [STW-1:0] status_in,
    input  logic           lim_we,
    input  logic [AW-1:0]  lim_wdata,
    input  logic           err_clr,
    output logic [AW-1:0]  mem_addr,
    output logic [AW-1:0]  mem_wdata,
    output logic           mem_we,
    output logic           mem_re,
    output logic [AW-1:0]  sp_out,
    output logic           trap,
    output logic           err_flag
);
    import stk_pkg::*;

    stk_state_e    state_q, state_d;
    stk_op_e       op;
    logic          accept;
    logic          is_frame;
    logic          sp_inc, sp_dec;
    logic [AW-1:0] sp, sp_back;
    logic [AW-1:0] lo_word, hi_word, hi_q;
    logic          hit;
    logic          err_q;

    assign op       = stk_op_e'(cmd_op);
    assign is_frame = (op == OP_CALL) || (op == OP_EXC);

    stk_ptr_reg #(.AW(AW), .RST_VAL(SP_RESET)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (sp_inc),
        .dec     (sp_dec),
        .sp      (sp),
        .sp_back (sp_back)
    );

    stk_frame_fmt #(.AW(AW), .PCW(PCW), .STW(STW)) u_fmt (
        .pc      (pc_in),
        .status  (status_in),
        .is_exc  (op == OP_EXC),
        .lo_word (lo_word),
        .hi_word (hi_word)
    );

    stk_bound_chk #(.AW(AW), .FLOOR(FLOOR)) u_bound (
        .clk       (clk),
        .rst_n     (rst_n),
        .lim_we    (lim_we),
        .lim_wdata (lim_wdata),
        .ea_valid  (mem_we | mem_re),
        .ea        (mem_addr),
        .hit       (hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lim_we)
                    state_d = ST_LIM_SETTLE;
                else if (accept && is_frame)
                    state_d = ST_FRAME_HI;
            end
            ST_FRAME_HI:   state_d = lim_we ? ST_LIM_SETTLE : ST_IDLE;
            ST_LIM_SETTLE: state_d = lim_we ? ST_LIM_SETTLE : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE) && !lim_we;
        accept    = cmd_valid && cmd_ready;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = push_data;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_PUSH: begin
                            mem_we = 1'b1;
                            sp_inc = 1'b1;
                        end
                        OP_POP: begin
                            mem_re   = 1'b1;
                            mem_addr = sp_back;
                            sp_dec   = 1'b1;
                        end
                        default: begin
                            mem_we    = 1'b1;
                            mem_wdata = lo_word;
                            sp_inc    = 1'b1;
                        end
                    endcase
                end
            end
            ST_FRAME_HI: begin
                mem_we    = 1'b1;
                mem_wdata = hi_q;
                sp_inc    = 1'b1;
            end
            ST_LIM_SETTLE: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (accept && is_frame)
            hi_q <= hi_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (hit)
            err_q <= 1'b1;
        else if (err_clr)
            err_q <= 1'b0;
    end

    assign trap     = hit;
    assign err_flag = err_q;
    assign sp_out   = sp;
endmodule

// File: rtl/stkptr_unit_chk.sv
module stkptr_unit_chk #(
    parameter int            AW    = 16,
    parameter logic [AW-1:0] FLOOR = 16'h0800
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          cmd_ready,
    input logic          lim_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] sp_out,
    input logic          trap,
    input logic          err_flag
);
    localparam logic [AW-1:0] WORD = AW'(2);

    // R4
    sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out[0] == 1'b0);

    // R2
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_out);

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_out) + WORD);

    // R3
    pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == sp_out - WORD);

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_out == $past(sp_out) - WORD);

    // R6
    floor_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && (mem_addr < FLOOR)) |-> trap);

    // R10
    trap_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (mem_we || mem_re));

    // R10
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> err_flag);

    // R9
    lim_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we |=> !cmd_ready);

    // R7
    frame_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op[1]) |=> (mem_we && !cmd_ready));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we || mem_re) |=> sp_out == $past(sp_out));

    // R2
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

bind stkptr_unit stkptr_unit_chk #(.AW(AW), .FLOOR(FLOOR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .lim_we    (lim_we),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .sp_out    (sp_out),
    .trap      (trap),
    .err_flag  (err_flag)
);

// File: tb/stkptr_unit_bench.sv
module stkptr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_ready;
    logic [15:0] push_data = '0;
    logic [22:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic        lim_we = 1'b0;
    logic [15:0] lim_wdata = '0;
    logic        err_clr = 1'b0;
    logic [15:0] mem_addr, mem_wdata, sp_out;
    logic        mem_we, mem_re, trap, err_flag;

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [15:0] m_sp = 16'h0800;
    logic [15:0] m_lim = '0;
    logic        m_armed = 1'b0;
    logic        m_err = 1'b0;

    localparam int NV = 17;
    // 0 push, 1 pop, 2 call, 3 exception
    localparam logic [1:0] OPS [NV] = '{2'd1, 2'd0, 2'd0, 2'd2, 2'd0, 2'd3, 2'd1, 2'd0,
                                        2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1};

    always #2 clk = ~clk;

    stkptr_unit u_stkptr_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .push_data(push_data), .pc_in(pc_in),
        .status_in(status_in), .lim_we(lim_we), .lim_wdata(lim_wdata),
        .err_clr(err_clr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .sp_out(sp_out), .trap(trap),
        .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_hit(input logic [15:0] a);
        return (a < 16'h0800) || (m_armed && (a > m_lim));
    endfunction

    task automatic chk_access(input string tag, input logic we, input logic [15:0] a,
                              input logic [15:0] d, input logic clr);
        logic t;
        t = m_hit(a);
        chk({tag, " we"}, mem_we, we);
        chk({tag, " re"}, mem_re, !we);
        chk({tag, " addr"}, mem_addr, a);
        if (we) chk({tag, " data"}, mem_wdata, d);
        chk({tag, " R5 R6 R10 trap"}, trap, t);
        if (t) m_err = 1'b1;
        else if (clr) m_err = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] op, input logic [15:0] d, input logic [22:0] pc,
                         input logic [7:0] st, input logic clr);
        string tg;
        tg = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : (op == 2'd2) ? "R7" : "R8";
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; push_data = d; pc_in = pc; status_in = st; err_clr = clr;
        #1;
        if (op == 2'd1) begin
            chk_access(tg, 1'b0, m_sp - 16'd2, '0, clr);
            m_sp = m_sp - 16'd2;
        end else begin
            chk_access(tg, 1'b1, m_sp, (op == 2'd0) ? d : pc[15:0], clr);
            m_sp = m_sp + 16'd2;
        end
        @(negedge clk);
        cmd_valid = 1'b0; err_clr = 1'b0;
        if (op[1]) begin
            #1;
            chk({tg, " ready low"}, cmd_ready, 1'b0);
            chk_access(tg, 1'b1, m_sp,
                       (op == 2'd3) ? {st, 1'b0, pc[22:16]} : {9'b0, pc[22:16]}, 1'b0);
            m_sp = m_sp + 16'd2;
            @(negedge clk);
        end
        #1;
        chk({tg, " sp"}, sp_out, m_sp);
        chk("R10 flag", err_flag, m_err);
        chk("R10 trap pulse ends", trap, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 during reset
        chk("R1 sp in reset", sp_out, 16'h0800);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 sp", sp_out, 16'h0800);
        chk("R1 ready", cmd_ready, 1'b1);
        chk("R1 trap", trap, 1'b0);
        chk("R1 flag", err_flag, 1'b0);
        chk("R1 we", mem_we, 1'b0);
        chk("R1 re", mem_re, 1'b0);

        // R5: limit not yet armed, no overflow trap
        do_op(2'd0, 16'h1111, '0, '0, 1'b0);
        do_op(2'd1, '0, '0, '0, 1'b0);

        // R9 / R11 / R4: limit write meets a push request
        @(negedge clk);
        lim_we = 1'b1; lim_wdata = 16'h0811; cmd_valid = 1'b1; cmd_op = 2'd0; push_data = 16'hDEAD;
        #1;
        chk("R9 ready during write", cmd_ready, 1'b0);
        chk("R11 no access during write", mem_we | mem_re, 1'b0);
        @(negedge clk);
        lim_we = 1'b0;
        #1;
        chk("R9 ready settle", cmd_ready, 1'b0);
        chk("R11 no access settle", mem_we | mem_re, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R9 ready back", cmd_ready, 1'b1);
        chk("R11 sp unchanged", sp_out, 16'h0800);
        m_lim = 16'h0810; m_armed = 1'b1;

        // table walk: mixed operations across floor and limit
        for (int i = 0; i < NV; i++) begin
            do_op(OPS[i], 16'hA000 + 16'(i), 23'h5A0000 + 23'(i * 23'h1235),
                  8'hC0 + 8'(i), 1'b0);
        end

        // R10: clear alone, then clear coinciding with a trap
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        m_err = 1'b0;
        #1;
        chk("R10 clear", err_flag, 1'b0);
        // R4: limit written as 0x0811 behaves as 0x0810 (push at 0x0810 allowed)
        do_op(2'd0, 16'h2222, '0, '0, 1'b1);
        do_op(2'd0, 16'h3333, '0, '0, 1'b1);
        chk("R10 set beats clear", err_flag, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule